// File: doc/BRIEF.md
# Auto-Reload Interval Down-Timer

This block counts down from a value that software writes. Each pulse on the time base tick input lowers the count by one. When a tick arrives while the count is 1, the timer has expired. It then stops at zero, or it restarts from the last written value when auto-reload is enabled. Each expiry sets a sticky status flag. The interrupt output is that flag gated by an interrupt enable. A higher layer of the chip already decodes the register writes and divides the clock down to ticks. The block sees only a write strobe with its data, two enable levels, a status-clear pulse and the tick.

The control path is a two-state machine:
- `PIT_IDLE`: the counter holds its value and ignores ticks.
- `PIT_RUN`: each tick decrements the counter.

It has four transitions:
- **start**: from `PIT_IDLE` to `PIT_RUN`, on a write of a non-zero value.
- **halt**: from `PIT_RUN` to `PIT_IDLE`, on a write of zero.
- **expire-stop**: from `PIT_RUN` to `PIT_IDLE`, on a tick at count 1 with auto-reload off.
- **expire-reload**: from `PIT_RUN` back to `PIT_RUN`, on a tick at count 1 with auto-reload on. The counter is reloaded from the shadow of the last written value.

A write taken while in `PIT_RUN` with a non-zero value stays in `PIT_RUN` and simply restarts the count.

Top module: `interval_timer`

## Requirements
- R1: After reset, `count` is 0, `status` is 0, `irq` is 0, and the timer is idle.
- R2: When `wr_en` is high, the next `count` equals `wr_data` and that value becomes the reload value. A write in the same cycle as a tick takes priority, so no decrement and no expiry happen in that cycle.
- R3: While running, each cycle with `tick` high lowers `count` by exactly 1. Cycles without `tick` leave `count` unchanged.
- R4: A tick at `count` 1 with `reload_en` low leaves `count` at 0. Later ticks change neither `count` nor `status`, even if `reload_en` is raised after that point.
- R5: Every expiry (a tick at `count` 1 while running, without a write) sets `status` in the next cycle. `status` then stays 1 until it is cleared.
- R6: A `sts_clr` pulse clears `status` in the next cycle. If an expiry happens in the same cycle, the expiry wins and `status` stays 1.
- R7: `irq` is 1 exactly when `status` is 1 and `irq_en` is 1.
- R8: A tick at `count` 1 with `reload_en` high reloads `count` with the last written value, and counting continues. A reload value of 1 therefore expires on every tick.
- R9: Writing 0 stops the timer with `count` at 0 and does not set `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time base tick, one decrement per pulse |
| wr_en | input | 1 | Software write strobe for the start value |
| wr_data | input | 32 | Start value; also kept as the reload value |
| reload_en | input | 1 | Auto-reload enable |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status flag |
| count | output | 32 | Current counter value |
| status | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL assertions check the following on every cycle:
- a write lands in the counter;
- a running tick lowers the count by one;
- an idle counter holds still, and a running counter is never zero;
- an expiry reloads from the shadow register;
- an expiry always sets the flag, and the flag stays set until cleared.

Some behaviours depend on ordered stimulus, so only the bench's scenarios show them:
- expiry at exactly the programmed distance;
- a write colliding with a tick;
- a clear colliding with an expiry;
- the halt write of zero;
- a reload value of 1.

The bench also checks the interrupt gating while the enable is toggled.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic {
        PIT_IDLE = 1'b0,
        PIT_RUN  = 1'b1
    } pit_state_e;
endpackage

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             reload_en,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    pit_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, shadow_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIT_IDLE;
        else        state_q <= state_d;
    end

    // next state: start, halt, expire-stop, expire-reload
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIT_IDLE: begin
                if (wr_en && wr_data != CNT_ZERO) state_d = PIT_RUN;
            end
            PIT_RUN: begin
                if (wr_en)
                    state_d = (wr_data != CNT_ZERO) ? PIT_RUN : PIT_IDLE;
                else if (tick && cnt_q == CNT_ONE && !reload_en)
                    state_d = PIT_IDLE;
            end
            default: state_d = PIT_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            PIT_RUN:  expire = tick && !wr_en && (cnt_q == CNT_ONE);
            default:  expire = 1'b0;
        endcase
    end

    // datapath: write beats tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= CNT_ZERO;
            shadow_q <= CNT_ZERO;
        end else if (wr_en) begin
            cnt_q    <= wr_data;
            shadow_q <= wr_data;
        end else if (expire) begin
            cnt_q    <= reload_en ? shadow_q : CNT_ZERO;
        end else if (state_q == PIT_RUN && tick) begin
            cnt_q    <= cnt_q - CNT_ONE;
        end
    end

    assign count = cnt_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt_q == $past(wr_data)); // R2
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIT_RUN && tick && !wr_en && cnt_q != CNT_ONE)
        |=> cnt_q == $past(cnt_q) - CNT_ONE); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIT_IDLE && !wr_en) |=> $stable(cnt_q)); // R4
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PIT_RUN |-> cnt_q != CNT_ZERO); // R9
    AST_RELOAD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_en) |=> cnt_q == $past(shadow_q)); // R8
endmodule

// File: rtl/pit_flag.sv
module pit_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic sts_clr,
    input  logic irq_en,
    output logic status,
    output logic irq
);
    logic sts_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (expire)  sts_q <= 1'b1;
        else if (sts_clr) sts_q <= 1'b0;
    end

    assign status = sts_q;
    assign irq    = sts_q & irq_en;

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sts_q); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !sts_clr) |=> sts_q); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !expire) |=> !sts_q); // R6
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             reload_en,
    input  logic             irq_en,
    input  logic             sts_clr,
    output logic [CNT_W-1:0] count,
    output logic             status,
    output logic             irq
);
    logic expire;

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .reload_en (reload_en),
        .count     (count),
        .expire    (expire)
    );

    pit_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .sts_clr (sts_clr),
        .irq_en  (irq_en),
        .status  (status),
        .irq     (irq)
    );

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !status |-> !irq); // R7
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, wr_en = 1'b0, reload_en = 1'b0;
    logic        irq_en = 1'b0, sts_clr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] count;
    logic        status, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [31:0] m_cnt = '0, m_shd = '0;
    bit          m_run = 0, m_sts = 0;
    string       tag = "R1";

    always #2 clk = ~clk; // 250 MHz

    interval_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .reload_en(reload_en), .irq_en(irq_en),
        .sts_clr(sts_clr), .count(count), .status(status), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp_v, input string what);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp_v);
        end
    endtask

    task automatic model_step();
        bit exp_now = 0;
        if (!rst_n) begin
            m_cnt = '0; m_shd = '0; m_run = 0; m_sts = 0;
            return;
        end
        if (wr_en) begin
            m_cnt = wr_data; m_shd = wr_data; m_run = (wr_data != 0);
        end else if (m_run && tick) begin
            if (m_cnt == 1) begin
                exp_now = 1;
                if (reload_en) m_cnt = m_shd;
                else begin m_cnt = 0; m_run = 0; end
            end else m_cnt = m_cnt - 1;
        end
        if (exp_now) m_sts = 1;
        else if (sts_clr) m_sts = 0;
    endtask

    // one cycle: inputs already set at negedge; compare after the edge
    task automatic cyc(input bit t, input bit w, input logic [31:0] d, input bit c);
        tick = t; wr_en = w; wr_data = d; sts_clr = c;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, count, m_cnt, "count");
        chk(tag, 32'(status), 32'(m_sts), "status");
        chk("R7", 32'(irq), 32'(m_sts & irq_en), "irq");
        tick = 0; wr_en = 0; sts_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", count, 0, "reset count");
        chk("R1", 32'(status), 0, "reset status");
        chk("R1", 32'(irq), 0, "reset irq");

        // one-shot: load 5, four ticks reach 1
        tag = "R2"; irq_en = 1;
        cyc(0, 1, 5, 0);
        chk("R2", count, 5, "loaded");
        tag = "R3";
        for (int i = 0; i < 4; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); end
        chk("R3", count, 1, "after four ticks");
        chk("R5", 32'(status), 0, "no early expiry");
        tag = "R5";
        cyc(1, 0, 0, 0);
        chk("R4", count, 0, "stopped at zero");
        chk("R5", 32'(status), 1, "expiry flag");
        chk("R7", 32'(irq), 1, "irq raised");

        // idle ticks, even with reload raised later
        tag = "R4"; reload_en = 1;
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
        chk("R4", count, 0, "idle stays zero");
        reload_en = 0;

        // irq gating and clear
        tag = "R7"; irq_en = 0;
        cyc(0, 0, 0, 0);
        chk("R7", 32'(irq), 0, "gated off");
        tag = "R6";
        cyc(0, 0, 0, 1);
        chk("R6", 32'(status), 0, "cleared");
        irq_en = 1;

        // auto-reload with gaps
        tag = "R8"; reload_en = 1;
        cyc(0, 1, 3, 0);
        for (int i = 0; i < 12; i++) cyc((i % 3) != 1, 0, 0, 0);
        chk("R8", 32'(status), 1, "reload expiries flagged");

        // clear colliding with expiry: expiry wins
        tag = "R6";
        cyc(0, 1, 1, 1);
        cyc(1, 0, 0, 1);
        chk("R6", 32'(status), 1, "expiry beats clear");
        chk("R8", count, 1, "reload value 1");
        cyc(0, 0, 0, 1);
        chk("R6", 32'(status), 0, "clear after");
        tag = "R8";
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0);
        chk("R5", 32'(status), 1, "every-tick expiry");
        cyc(0, 0, 0, 1);

        // write colliding with tick at count 1
        tag = "R2"; reload_en = 0;
        cyc(0, 1, 2, 0);
        cyc(1, 0, 0, 0);
        cyc(1, 1, 9, 0);
        chk("R2", count, 9, "write beats tick");
        chk("R2", 32'(status), 0, "no expiry on collision");

        // halt by writing zero
        tag = "R9";
        cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 0);
        chk("R9", count, 0, "halted");
        chk("R9", 32'(status), 0, "halt sets no flag");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        chk("R9", count, 0, "halted stays");

        // full-width value
        tag = "R3";
        cyc(0, 1, 32'hFFFF_FFFF, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
        chk("R3", count, 32'hFFFF_FFF9, "wide decrement");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule